// File: doc/BRIEF.md
# Flywheel Field-Sequence Sync Controller

This block keeps the horizontal, vertical and field position of a video encoder across an eight-field colour sequence. It has a pixel counter, a line counter and a 3-bit field index. It decodes line sync and field sync levels from those counters. In master mode it runs freely and its sync outputs pace the rest of the system.

In slave mode the block watches a line-sync input and a field-sync input. A field-start event is seen when a line-sync falling edge and a field-sync event fall on the same clock. The field-sync input can be a classic vertical pulse or a field toggle. The block locks to these events only at the start of odd-numbered fields. Through the even-numbered fields it flywheels on its own counters.

The sequence restarts on a rising edge of a hardware restart input, or while a software reset bit is held. After a restart the counters sit at the start of field 8. The master/slave choice is latched only at defined points, so it never changes within a frame.

Top module: `vsync_flywheel_ctrl`

## Requirements
- R1: While `rst_n` is low, `pix_cnt` = 0, `line_cnt` = 0, `field_idx` = 7 and `sync_oe` = 0. `field_idx` values 0..7 stand for fields 1..8, so an odd `field_idx` is an even-numbered field.
- R2: With no restart and no accepted event, `pix_cnt` counts 0..LINE_CLKS-1. When it wraps, `line_cnt` steps up. `line_cnt` counts 0..FIELD_LINES-1, and when it wraps, `field_idx` steps up modulo 8.
- R3: `hsout` is 0 while `pix_cnt` < HS_WIDTH and 1 otherwise.
- R4: When `vsout_toggle` = 0, `vsout` is 0 while `line_cnt` < VS_LINES and 1 otherwise. When `vsout_toggle` = 1, `vsout` equals bit 0 of `field_idx`, which is 0 in fields 1, 3, 5 and 7.
- R5: A field-start event is a falling edge of `hsin` on the same clock edge as a field-sync event. The field-sync event is a falling edge of `vsin` when `vsin_toggle` = 0, and any change of `vsin` when `vsin_toggle` = 1. A falling edge of `hsin` alone is not an event.
- R6: In slave mode, an event seen while `field_idx` is odd loads `pix_cnt` = 0, `line_cnt` = 0 and `field_idx` + 1 on that same clock edge. This holds wherever the counters stood.
- R7: In slave mode, an event seen while `field_idx` is even is ignored, and the counters keep counting as in R2.
- R8: In master mode, events have no effect on the counters.
- R9: A rising edge of `hw_restart`, and every clock with `sw_reset` = 1, sets `pix_cnt` = 0, `line_cnt` = 0 and `field_idx` = 7 on that edge. A restart takes priority over an event.
- R10: The latched mode (`sync_oe` = 1 for master, 0 for slave) takes the value of `master_sel` at three points only: the first clock after reset, any restart, and the edge where the counters enter `field_idx` 0 from `field_idx` 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_sel | input | 1 | Requested mode: 1 master, 0 slave |
| vsin_toggle | input | 1 | 1: `vsin` is a field toggle; 0: `vsin` is a vertical pulse |
| vsout_toggle | input | 1 | 1: `vsout` is a field toggle; 0: `vsout` is a vertical pulse |
| hw_restart | input | 1 | Restarts the sequence on its rising edge |
| sw_reset | input | 1 | Holds the generator at its start state while 1 |
| hsin | input | 1 | External line sync, falling edge active |
| vsin | input | 1 | External field sync |
| hsout | output | 1 | Line sync, low for HS_WIDTH clocks per line |
| vsout | output | 1 | Field sync, in pulse or toggle form |
| sync_oe | output | 1 | Latched mode, 1 when the sync outputs drive the system |
| pix_cnt | output | $clog2(LINE_CLKS) | Pixel position in the line |
| line_cnt | output | $clog2(FIELD_LINES) | Line position in the field |
| field_idx | output | 3 | Field in the sequence, 0..7 for fields 1..8 |

## Verification
Assertions check on every cycle that the counters stay in range and step correctly at line and field wraps. They also check that an accepted event lands on pixel 0, line 0 of an odd-numbered field, that a restart lands at field 8, that the master-mode counters do not react to sync input, that the latched mode holds between its sampling points, and that `hsout` rises exactly at HS_WIDTH. Other behaviours can only be shown by scenarios: that an event in an odd-numbered field leaves the count untouched, that toggle-style `vsin` recognises both edges, that a lone `hsin` edge is not an event, and that a `master_sel` change waits for the next frame start. The bench drives these cases both directly and under random sync traffic.

// File: rtl/vfw_pkg.sv
package vfw_pkg;

  typedef logic [2:0] field_idx_t;

  typedef enum logic {
    MODE_SLAVE  = 1'b0,
    MODE_MASTER = 1'b1
  } sync_mode_e;

  localparam field_idx_t FIELD_LAST = 3'd7;

  // line sync level: low during the first width clocks of a line
  function automatic logic hs_level(int unsigned pix, int unsigned width);
    return (pix >= width);
  endfunction

  // vertical pulse level: low during the first vs_lines lines of a field
  function automatic logic vs_pulse_level(int unsigned line, int unsigned vs_lines);
    return (line >= vs_lines);
  endfunction

  // field toggle level: 0 in fields 1,3,5,7 and 1 in fields 2,4,6,8
  function automatic logic vs_toggle_level(field_idx_t f);
    return f[0];
  endfunction

  // true while the counters are inside field 2, 4, 6 or 8
  function automatic logic in_even_numbered(field_idx_t f);
    return f[0];
  endfunction

  function automatic field_idx_t field_after(field_idx_t f);
    return f + 3'd1;
  endfunction

endpackage

// File: rtl/vfw_sync_detect.sv
module vfw_sync_detect #(
  parameter int unsigned SYNC_DEPTH = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsin,
  input  logic vsin,
  input  logic vsin_toggle,
  output logic fld_evt
);

  logic hs_s, vs_s;
  logic hs_q, vs_q;
  logic hs_fall, vs_evt;

  generate
    if (SYNC_DEPTH == 0) begin : g_direct
      assign hs_s = hsin;
      assign vs_s = vsin;
    end else begin : g_sync
      logic [SYNC_DEPTH-1:0] hs_pipe, vs_pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hs_pipe <= '1;
          vs_pipe <= '1;
        end else begin
          hs_pipe <= {hs_pipe[SYNC_DEPTH-1:0] , hsin} >> 0;
          vs_pipe <= {vs_pipe[SYNC_DEPTH-1:0] , vsin} >> 0;
        end
      end
      assign hs_s = hs_pipe[SYNC_DEPTH-1];
      assign vs_s = vs_pipe[SYNC_DEPTH-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      vs_q <= 1'b1;
    end else begin
      hs_q <= hs_s;
      vs_q <= vs_s;
    end
  end

  assign hs_fall = hs_q & ~hs_s;
  assign vs_evt  = vsin_toggle ? (vs_q ^ vs_s) : (vs_q & ~vs_s);
  assign fld_evt = hs_fall & vs_evt;

  // R5: an event always coincides with a line-sync level that was high last cycle
  p_evt_needs_hs_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fld_evt |-> (hs_q && !hs_s));

endmodule

// File: rtl/vfw_timebase.sv
module vfw_timebase #(
  parameter int unsigned LINE_CLKS   = 858,
  parameter int unsigned FIELD_LINES = 525,
  localparam int unsigned PW = $clog2(LINE_CLKS),
  localparam int unsigned LW = $clog2(FIELD_LINES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                accept,
  output logic [PW-1:0]       pix,
  output logic [LW-1:0]       line,
  output vfw_pkg::field_idx_t field,
  output logic                end_pix,
  output logic                end_line,
  output logic                frame_start
);
  import vfw_pkg::*;

  localparam logic [PW-1:0] PIX_LAST  = PW'(LINE_CLKS - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(FIELD_LINES - 1);

  assign end_pix  = (pix == PIX_LAST);
  assign end_line = (line == LINE_LAST);

  // counters move into field 1 from field 8, by wrap or by accepted event
  assign frame_start = !restart && (field == FIELD_LAST) && (accept || (end_pix && end_line));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix   <= '0;
      line  <= '0;
      field <= FIELD_LAST;
    end else if (restart) begin
      pix   <= '0;
      line  <= '0;
      field <= FIELD_LAST;
    end else if (accept) begin
      pix   <= '0;
      line  <= '0;
      field <= field_after(field);
    end else if (end_pix) begin
      pix <= '0;
      if (end_line) begin
        line  <= '0;
        field <= field_after(field);
      end else begin
        line <= line + 1'b1;
      end
    end else begin
      pix <= pix + 1'b1;
    end
  end

  p_pix_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix <= PIX_LAST) && (line <= LINE_LAST));

  p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !accept && end_pix && !end_line) |=>
      (pix == '0) && (line == $past(line) + 1'b1) && (field == $past(field)));

  p_field_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !accept && end_pix && end_line) |=>
      (line == '0) && (field == $past(field) + 3'd1));

endmodule

// File: rtl/vfw_sync_out.sv
module vfw_sync_out #(
  parameter int unsigned HS_WIDTH = 64,
  parameter int unsigned VS_LINES = 3,
  parameter int unsigned PW       = 10,
  parameter int unsigned LW       = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PW-1:0]       pix,
  input  logic [LW-1:0]       line,
  input  vfw_pkg::field_idx_t field,
  input  logic                vs_toggle,
  output logic                hsout,
  output logic                vsout
);
  import vfw_pkg::*;

  assign hsout = hs_level(32'(pix), HS_WIDTH);
  assign vsout = vs_toggle ? vs_toggle_level(field) : vs_pulse_level(32'(line), VS_LINES);

  // R3: the line sync ends exactly HS_WIDTH clocks into the line
  p_hs_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsout) |-> (32'(pix) == HS_WIDTH));

endmodule

// File: rtl/vsync_flywheel_ctrl.sv
module vsync_flywheel_ctrl #(
  parameter int unsigned LINE_CLKS   = 858,
  parameter int unsigned FIELD_LINES = 525,
  parameter int unsigned HS_WIDTH    = 64,
  parameter int unsigned VS_LINES    = 3,
  parameter int unsigned SYNC_DEPTH  = 0,
  localparam int unsigned PW = $clog2(LINE_CLKS),
  localparam int unsigned LW = $clog2(FIELD_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_sel,
  input  logic          vsin_toggle,
  input  logic          vsout_toggle,
  input  logic          hw_restart,
  input  logic          sw_reset,
  input  logic          hsin,
  input  logic          vsin,
  output logic          hsout,
  output logic          vsout,
  output logic          sync_oe,
  output logic [PW-1:0] pix_cnt,
  output logic [LW-1:0] line_cnt,
  output logic [2:0]    field_idx
);
  import vfw_pkg::*;

  logic       hw_q, hw_rise, restart;
  logic       init_q;
  sync_mode_e mode_q;
  logic       fld_evt, accept;
  logic       end_pix, end_line, frame_start;
  field_idx_t field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_q <= 1'b1;
    else        hw_q <= hw_restart;
  end

  assign hw_rise = hw_restart & ~hw_q;
  assign restart = hw_rise | sw_reset;

  vfw_sync_detect #(.SYNC_DEPTH(SYNC_DEPTH)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsin       (hsin),
    .vsin       (vsin),
    .vsin_toggle(vsin_toggle),
    .fld_evt    (fld_evt)
  );

  assign accept = fld_evt && (mode_q == MODE_SLAVE) && in_even_numbered(field) && !restart;

  vfw_timebase #(.LINE_CLKS(LINE_CLKS), .FIELD_LINES(FIELD_LINES)) u_time (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .accept     (accept),
    .pix        (pix_cnt),
    .line       (line_cnt),
    .field      (field),
    .end_pix    (end_pix),
    .end_line   (end_line),
    .frame_start(frame_start)
  );

  assign field_idx = field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      mode_q <= MODE_SLAVE;
    end else begin
      init_q <= 1'b0;
      if (init_q || restart || frame_start)
        mode_q <= master_sel ? MODE_MASTER : MODE_SLAVE;
    end
  end

  assign sync_oe = (mode_q == MODE_MASTER);

  vfw_sync_out #(.HS_WIDTH(HS_WIDTH), .VS_LINES(VS_LINES), .PW(PW), .LW(LW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix      (pix_cnt),
    .line     (line_cnt),
    .field    (field),
    .vs_toggle(vsout_toggle),
    .hsout    (hsout),
    .vsout    (vsout)
  );

  p_accept_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pix_cnt == '0) && (line_cnt == '0) && !field_idx[0]);

  p_restart_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pix_cnt == '0) && (line_cnt == '0) && (field_idx == 3'd7));

  p_master_ignores_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_MASTER && !restart && !end_pix) |=> (pix_cnt == $past(pix_cnt) + 1'b1));

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_q && !restart && !frame_start) |=> $stable(mode_q));

endmodule

// File: tb/vsync_flywheel_ctrl_test.sv
`timescale 1ns/1ps
module vsync_flywheel_ctrl_test;
  localparam int LC = 12, FL = 5, HSW = 3, VSL = 2;
  localparam int PW = $clog2(LC), LW = $clog2(FL);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, master_sel, vsin_toggle, vsout_toggle, hw_restart, sw_reset, hsin, vsin;
  logic hsout, vsout, sync_oe;
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;
  logic [2:0] field_idx;

  vsync_flywheel_ctrl #(.LINE_CLKS(LC), .FIELD_LINES(FL), .HS_WIDTH(HSW), .VS_LINES(VSL),
                        .SYNC_DEPTH(0)) uut (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .vsin_toggle(vsin_toggle),
    .vsout_toggle(vsout_toggle), .hw_restart(hw_restart), .sw_reset(sw_reset),
    .hsin(hsin), .vsin(vsin), .hsout(hsout), .vsout(vsout), .sync_oe(sync_oe),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .field_idx(field_idx));

  int checks = 0, errors = 0, cyc = 0;
  string cur_tag = "R1";
  bit chk_en = 0, done = 0;

  // reference state built from the requirements
  int m_p, m_l;
  logic [2:0] m_f;
  logic m_mode, m_init, m_hsq, m_vsq, m_hwq;
  logic e_evt, e_rs, e_acc, e_frame;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_p = 0; m_l = 0; m_f = 3'd7; m_mode = 0; m_init = 1;
      m_hsq = 1; m_vsq = 1; m_hwq = 1;
    end else begin
      e_evt = (m_hsq && !hsin) && (vsin_toggle ? (m_vsq != vsin) : (m_vsq && !vsin));
      e_rs  = (hw_restart && !m_hwq) || sw_reset;
      e_acc = e_evt && !m_mode && m_f[0] && !e_rs;
      e_frame = !e_rs && m_f == 3'd7 && (e_acc || (m_p == LC-1 && m_l == FL-1));
      if (m_init || e_rs || e_frame) m_mode = master_sel;
      if (e_rs) begin m_p = 0; m_l = 0; m_f = 3'd7; end
      else if (e_acc) begin m_p = 0; m_l = 0; m_f = m_f + 3'd1; end
      else if (m_p == LC-1) begin
        m_p = 0;
        if (m_l == FL-1) begin m_l = 0; m_f = m_f + 3'd1; end
        else m_l = m_l + 1;
      end else m_p = m_p + 1;
      m_hsq = hsin; m_vsq = vsin; m_hwq = hw_restart; m_init = 0;
    end
  end

  function automatic int exp_hs(int p);
    return (p >= HSW) ? 1 : 0;
  endfunction

  function automatic int exp_vs(int l, logic [2:0] f, logic tg);
    return tg ? int'(f[0]) : ((l >= VSL) ? 1 : 0);
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      cmp(cur_tag, "pix_cnt", int'(pix_cnt), m_p);
      cmp(cur_tag, "line_cnt", int'(line_cnt), m_l);
      cmp(cur_tag, "field_idx", int'(field_idx), int'(m_f));
      cmp("R3", "hsout", int'(hsout), exp_hs(m_p));
      cmp("R4", "vsout", int'(vsout), exp_vs(m_l, m_f, vsout_toggle));
      cmp("R10", "sync_oe", int'(sync_oe), int'(m_mode));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog run did not complete");
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_state(int f, int l, int p);
    do step(1); while (!(int'(m_f) == f && m_l == l && m_p == p));
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; master_sel = 0; vsin_toggle = 0; vsout_toggle = 0;
    hw_restart = 0; sw_reset = 0; hsin = 1; vsin = 1;
    chk_en = 1;
    step(3);
    cmp("R1", "reset field_idx", int'(field_idx), 7);
    cmp("R1", "reset sync_oe", int'(sync_oe), 0);
    rst_n = 1;

    cur_tag = "R2";
    step(3 * LC * FL);

    // R6: event inside field 2, away from the field boundary
    cur_tag = "R6";
    wait_state(1, 2, 4);
    hsin = 0; vsin = 0;
    step(1);
    cmp("R6", "realign pix", int'(pix_cnt), 0);
    cmp("R6", "realign field", int'(field_idx), 2);
    step(1); hsin = 1; vsin = 1; step(3);

    // R7: event inside field 3 is ignored
    cur_tag = "R7";
    wait_state(2, 2, 4);
    hsin = 0; vsin = 0;
    step(1);
    cmp("R7", "flywheel pix", int'(pix_cnt), 5);
    cmp("R7", "flywheel field", int'(field_idx), 2);
    step(1); hsin = 1; vsin = 1; step(3);

    // R5: lone hsin edge, then toggle-style vsin on both edges
    cur_tag = "R5";
    wait_state(3, 2, 4);
    hsin = 0;
    step(1);
    cmp("R5", "hsin alone pix", int'(pix_cnt), 5);
    hsin = 1; vsin_toggle = 1; step(2);
    wait_state(5, 1, 3);
    hsin = 0; vsin = 0;
    step(1);
    cmp("R5", "toggle fall pix", int'(pix_cnt), 0);
    hsin = 1; step(2);
    wait_state(7, 1, 3);
    hsin = 0;
    step(1);
    cmp("R5", "no vsin change pix", int'(pix_cnt), 4);
    hsin = 1; step(2);
    wait_state(1, 1, 3);
    hsin = 0; vsin = 1;
    step(1);
    cmp("R5", "toggle rise pix", int'(pix_cnt), 0);
    hsin = 1; vsin_toggle = 0; step(2);

    // R9: hardware edge and held software reset
    cur_tag = "R9";
    hw_restart = 1;
    step(1);
    cmp("R9", "hw restart field", int'(field_idx), 7);
    cmp("R9", "hw restart pix", int'(pix_cnt), 0);
    step(3);
    cmp("R9", "level does not restart", int'(pix_cnt), 3);
    hw_restart = 0; sw_reset = 1;
    step(4);
    cmp("R9", "sw reset hold pix", int'(pix_cnt), 0);
    sw_reset = 0;
    step(1);
    cmp("R9", "after sw reset pix", int'(pix_cnt), 1);

    // R8: master mode ignores sync input
    cur_tag = "R8";
    master_sel = 1; vsout_toggle = 1; sw_reset = 1;
    step(1);
    sw_reset = 0;
    step(1);
    cmp("R8", "master latched", int'(sync_oe), 1);
    wait_state(1, 2, 4);
    hsin = 0; vsin = 0;
    step(1);
    cmp("R8", "master ignores pix", int'(pix_cnt), 5);
    step(1); hsin = 1; vsin = 1; step(2);

    // R10: mode change waits for the next frame start
    cur_tag = "R10";
    wait_state(2, 0, 0);
    master_sel = 0;
    step(1);
    cmp("R10", "mode held mid frame", int'(sync_oe), 1);
    wait_state(0, 0, 0);
    cmp("R10", "mode taken at frame start", int'(sync_oe), 0);
    vsout_toggle = 0;

    // random sync traffic with occasional mode and restart changes
    cur_tag = "R6";
    for (int i = 0; i < 6000; i++) begin
      hsin = ($urandom % 4) != 0;
      if (($urandom % 3) == 0) vsin = ~vsin;
      if (($urandom % 300) == 0) vsin_toggle = ~vsin_toggle;
      if (($urandom % 200) == 0) master_sel = ~master_sel;
      if (($urandom % 150) == 0) vsout_toggle = ~vsout_toggle;
      hw_restart = ($urandom % 500) == 0;
      sw_reset = ($urandom % 700) == 0;
      step(1);
    end
    hw_restart = 0; sw_reset = 0;
    step(2);
    finish_run();
  end

endmodule